// File: doc/BRIEF.md
# Calendar Clock Core with Snapshot Reads and Staged Writes

This block keeps wall-clock time and calendar date from seconds up to a two-digit year covering 2000 to 2099. It advances once for every one-cycle pulse on a once-per-second enable. It handles months of 28, 29, 30 and 31 days and detects leap years. A control bit in the hours byte selects 24-hour or 12-hour AM/PM counting. Every field is held in BCD.

A host reaches the time through a byte-addressed port built around transactions.

- **Reads:** starting a read copies the live time into a snapshot. All read bytes come from that snapshot while the live counters keep running.
- **Writes:** starting a write copies the live time into a shadow buffer. Byte writes then replace shadow bytes, one at a time. A valid commit moves the whole shadow into the live counters in one edge. An abort throws the shadow away.
- **After reset:** reset models total power loss. The clock then stays halted until a commit that carried at least one byte write.

The host is expected to write only valid BCD values for each field.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the live time is 00:00:00 in 24-hour mode (hours byte 0x80), date 0x01, month 0x01, year 0x00, weekday 0x00. The snapshot reads 0x00 at every address until the first read start.
- R2: After reset, ticks leave the time unchanged until a commit occurs whose transaction wrote at least one byte. A commit with no byte written does not start the clock.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. Each wraps to 0x00, and the wrap of one carries into the next field.
- R4: Hours byte bit 7 = 1 selects 24-hour mode, with the hour in bits 5:0 as BCD 00 to 23. In this mode 23 wraps to 00 and advances the date.
- R5: Hours byte bit 7 = 0 selects 12-hour mode, with the hour in bits 4:0 as BCD 1 to 12 and bit 6 = PM. In this mode:
  - 11 goes to 12 and toggles PM.
  - 12 goes to 01.
  - Only 11 PM to 12 AM advances the date.
- R6: The date wraps to 0x01 after day 30 in months 0x04, 0x06, 0x09 and 0x11, and after day 31 in all other months except February. A date wrap advances the month.
- R7: February ends on day 29 when the binary year is a multiple of 4 (year 00 included), and on day 28 otherwise. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R8: The weekday counts 0 to 6 on every date advance and wraps from 6 to 0, whatever the date.
- R9: A read start pulse captures the live time. From the next cycle, rd_data shows the captured byte at addr: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday. Address 7 reads 0x00. The captured bytes do not change while ticks occur.
- R10: A write start loads the shadow from the live time. A wr_en inside the transaction replaces one shadow byte, and address 7 is ignored. The live time is unaffected until commit, and a wr_en outside a transaction has no effect.
- R11: A commit inside a transaction copies the shadow into the live time at that edge, including a byte written in the same cycle. Bytes not written keep their value from the write start, and later ticks count on from the committed value.
- R12: An abort ends the transaction and leaves the live time unchanged, and it wins over a commit in the same cycle. A commit outside a transaction is ignored.
- R13: A tick in the same cycle as a commit is dropped, so the committed value holds until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (total power loss) |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| rd_start | input | 1 | Start of a read transaction; captures the snapshot |
| wr_start | input | 1 | Start of a write transaction; loads the shadow |
| wr_en | input | 1 | Write one byte of the shadow |
| wr_commit | input | 1 | Valid end of write; commit the shadow |
| wr_abort | input | 1 | Invalid end of write; discard the shadow |
| addr | input | ADDR_W | Byte address of the field |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Snapshot byte at addr |

## Verification
The counting chain is driven by a table of start times, each followed by exactly one tick. Each entry sits on a different carry boundary:
- a plain second step;
- minute and hour carries;
- midnight in both hour modes, plus noon and the 12 to 01 step;
- ends of 30-day and 31-day months;
- February 28 in a common and in a leap year, and February 29;
- the end of year 99.

Because one tick moves exactly one position, each entry shows whether a given wrap limit or carry path is off by one.

Directed sequences then cover the transaction rules:
- ticks while halted, and an empty commit;
- ticks during a read;
- a partial write with ticks during the transaction;
- writes outside a transaction;
- aborts, including abort and commit in the same cycle;
- a commit that coincides with both a tick and a byte write.

Together these separate snapshot-versus-live and shadow-versus-live behaviour.

// File: rtl/rtc_cal_pkg.sv
// Package: shared widths, field indices, time record and BCD helpers
// for the calendar clock core. Assumes all stored values are BCD.
package rtc_cal_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 7;

    localparam int FLD_SEC   = 0;
    localparam int FLD_MIN   = 1;
    localparam int FLD_HOUR  = 2;
    localparam int FLD_DATE  = 3;
    localparam int FLD_MONTH = 4;
    localparam int FLD_YEAR  = 5;
    localparam int FLD_DOW   = 6;

    // hours byte layout
    localparam int HOUR_MODE_BIT = 7;   // 1 = 24-hour
    localparam int HOUR_PM_BIT   = 6;   // 12-hour only

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] dow;
    } rtc_time_t;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] rtc_bytes_t;

    localparam rtc_time_t RESET_TIME = '{
        sec: 8'h00, min: 8'h00, hour: 8'h80, date: 8'h01,
        month: 8'h01, year: 8'h00, dow: 8'h00
    };

    // two BCD digits to binary
    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        int v;
        v = int'(b[7:4]) * 10 + int'(b[3:0]);
        return 7'(v);
    endfunction

    // binary 0..99 to two BCD digits
    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // time record to byte array indexed by field number
    function automatic rtc_bytes_t to_bytes(input rtc_time_t t);
        rtc_bytes_t b;
        b[FLD_SEC]   = t.sec;
        b[FLD_MIN]   = t.min;
        b[FLD_HOUR]  = t.hour;
        b[FLD_DATE]  = t.date;
        b[FLD_MONTH] = t.month;
        b[FLD_YEAR]  = t.year;
        b[FLD_DOW]   = t.dow;
        return b;
    endfunction

    // byte array to time record
    function automatic rtc_time_t from_bytes(input rtc_bytes_t b);
        rtc_time_t t;
        t.sec   = b[FLD_SEC];
        t.min   = b[FLD_MIN];
        t.hour  = b[FLD_HOUR];
        t.date  = b[FLD_DATE];
        t.month = b[FLD_MONTH];
        t.year  = b[FLD_YEAR];
        t.dow   = b[FLD_DOW];
        return t;
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
// Module: last day number of a month, with leap-year February.
// Assumes month is BCD 01..12 and year is BCD 00..99 (2000..2099),
// so every year divisible by four is a leap year.
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] month_bcd,
    input  logic [BYTE_W-1:0] year_bcd,
    output logic [4:0]        last_day
);

    logic [6:0] year_bin;
    logic       leap;

    // leap detection from binary year
    always_comb begin
        year_bin = bcd2bin(year_bcd);
        leap     = (year_bin[1:0] == 2'b00);
    end

    // month length lookup
    always_comb begin
        case (month_bcd)
            8'h02:                      last_day = leap ? 5'd29 : 5'd28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 5'd30;
            default:                    last_day = 5'd31;
        endcase
    end

endmodule

// File: rtl/rtc_time_counter.sv
// Module: live time registers and their one-second advance chain.
// A load (commit) overrides a tick in the same cycle. The counter stays
// halted after reset until a load arrives with arm set.
// Assumes loaded values are valid BCD.
module rtc_time_counter
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  logic      arm,
    input  rtc_time_t load_val,
    output rtc_time_t cur,
    output logic      running
);

    rtc_time_t  nxt;
    logic [4:0] last_day;
    logic [6:0] s_b, m_b, h_b, d_b, mo_b, y_b, w_b;
    logic [7:0] h_bcd;
    logic       c_min, c_hr, c_day, c_mon, c_yr, pm_n;

    rtc_month_len u_len (
        .month_bcd (cur.month),
        .year_bcd  (cur.year),
        .last_day  (last_day)
    );

    // compute the time one second after cur
    always_comb begin
        nxt   = cur;
        s_b   = bcd2bin(cur.sec);
        m_b   = bcd2bin(cur.min);
        h_b   = bcd2bin({2'b00, cur.hour[5:0]});
        d_b   = bcd2bin(cur.date);
        mo_b  = bcd2bin(cur.month);
        y_b   = bcd2bin(cur.year);
        w_b   = bcd2bin(cur.dow);
        h_bcd = 8'h00;
        pm_n  = cur.hour[HOUR_PM_BIT];
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        if (s_b >= 7'd59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bin2bcd(s_b + 7'd1);
        end

        if (c_min) begin
            if (m_b >= 7'd59) begin
                nxt.min = 8'h00;
                c_hr    = 1'b1;
            end else begin
                nxt.min = bin2bcd(m_b + 7'd1);
            end
        end

        if (c_hr) begin
            if (cur.hour[HOUR_MODE_BIT]) begin
                if (h_b >= 7'd23) begin
                    h_bcd = 8'h00;
                    c_day = 1'b1;
                end else begin
                    h_bcd = bin2bcd(h_b + 7'd1);
                end
                nxt.hour = {2'b10, h_bcd[5:0]};
            end else begin
                if (h_b == 7'd11) begin
                    h_bcd = 8'h12;
                    pm_n  = ~cur.hour[HOUR_PM_BIT];
                    c_day = cur.hour[HOUR_PM_BIT];
                end else if (h_b >= 7'd12) begin
                    h_bcd = 8'h01;
                end else begin
                    h_bcd = bin2bcd(h_b + 7'd1);
                end
                nxt.hour = {1'b0, pm_n, h_bcd[5:0]};
            end
        end

        if (c_day) begin
            if (d_b >= {2'b00, last_day}) begin
                nxt.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = bin2bcd(d_b + 7'd1);
            end
            nxt.dow = (w_b >= 7'd6) ? 8'h00 : bin2bcd(w_b + 7'd1);
        end

        if (c_mon) begin
            if (mo_b >= 7'd12) begin
                nxt.month = 8'h01;
                c_yr      = 1'b1;
            end else begin
                nxt.month = bin2bcd(mo_b + 7'd1);
            end
        end

        if (c_yr) begin
            nxt.year = (y_b >= 7'd99) ? 8'h00 : bin2bcd(y_b + 7'd1);
        end
    end

    // live time register: commit first, then tick while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RESET_TIME;
        end else if (load) begin
            cur <= load_val;
        end else if (tick && running) begin
            cur <= nxt;
        end
    end

    // run flag: set by the first commit that carried a written byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (load && arm) begin
            running <= 1'b1;
        end
    end

endmodule

// File: rtl/rtc_host_port.sv
// Module: host access side. It holds the read snapshot and the write
// shadow, and tracks the write transaction. It emits a one-cycle commit
// with the merged shadow, and an arm flag when any byte was written.
// Assumes start/commit/abort are single-cycle pulses.
module rtc_host_port
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rtc_time_t         live,
    input  logic              rd_start,
    input  logic              wr_start,
    input  logic              wr_en,
    input  logic              wr_commit,
    input  logic              wr_abort,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              commit,
    output logic              commit_arm,
    output rtc_time_t         commit_val,
    output rtc_time_t         snap
);

    rtc_bytes_t            live_b, snap_b, shadow_q, shadow_nxt;
    logic [NUM_FIELDS-1:0] hit;
    logic                  active_q, dirty_q, dirty_nxt;

    assign live_b = to_bytes(live);
    assign snap_b = to_bytes(snap);

    // per-field shadow update: reload on start, else take a hit byte
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        always_comb begin
            hit[g] = wr_en && active_q && !wr_start && (addr == ADDR_W'(g));
            if (wr_start)    shadow_nxt[g] = live_b[g];
            else if (hit[g]) shadow_nxt[g] = wr_data;
            else             shadow_nxt[g] = shadow_q[g];
        end
    end

    // commit decode and merged value
    always_comb begin
        dirty_nxt  = dirty_q || (|hit);
        commit     = active_q && wr_commit && !wr_abort && !wr_start;
        commit_arm = dirty_nxt;
        commit_val = from_bytes(shadow_nxt);
    end

    // shadow storage
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_nxt;
    end

    // transaction state: open on start, close on commit or abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            dirty_q  <= 1'b0;
        end else if (wr_start) begin
            active_q <= 1'b1;
            dirty_q  <= 1'b0;
        end else if (active_q && (wr_commit || wr_abort)) begin
            active_q <= 1'b0;
            dirty_q  <= 1'b0;
        end else begin
            dirty_q  <= dirty_nxt;
        end
    end

    // read snapshot capture
    always_ff @(posedge clk) begin
        if (!rst_n)        snap <= '0;
        else if (rd_start) snap <= live;
    end

    // read mux from the snapshot; unused addresses read zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(i)) rd_data = snap_b[i];
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
// Module: top of the calendar clock core. It joins the host port
// (snapshot, shadow, transaction rules) to the live time counter.
// Assumes tick_1hz is a one-cycle pulse and ADDR_W >= 3.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              rd_start,
    input  logic              wr_start,
    input  logic              wr_en,
    input  logic              wr_commit,
    input  logic              wr_abort,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);

    rtc_time_t live_time, snap_time, commit_time;
    logic      do_commit, commit_arm, running;

    rtc_host_port #(.ADDR_W(ADDR_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .live       (live_time),
        .rd_start   (rd_start),
        .wr_start   (wr_start),
        .wr_en      (wr_en),
        .wr_commit  (wr_commit),
        .wr_abort   (wr_abort),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .commit     (do_commit),
        .commit_arm (commit_arm),
        .commit_val (commit_time),
        .snap       (snap_time)
    );

    rtc_time_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (do_commit),
        .arm      (commit_arm),
        .load_val (commit_time),
        .cur      (live_time),
        .running  (running)
    );

endmodule

// File: rtl/rtc_calendar_core_chk.sv
// Module: property checker for the calendar clock core, bound to the top.
// Assumes the host only writes valid BCD field values.
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick_1hz,
    input logic      rd_start,
    input logic      wr_abort,
    input logic      running,
    input logic      do_commit,
    input rtc_time_t commit_time,
    input rtc_time_t live_time,
    input rtc_time_t snap_time
);

    assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_time.sec <= 8'h59) && (live_time.sec[3:0] <= 4'd9));

    assert_month_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_time.month >= 8'h01) && (live_time.month <= 8'h12));

    assert_dow_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_time.dow <= 8'h06);

    assert_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !do_commit) |=> $stable(live_time));

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(snap_time));

    assert_abort_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !tick_1hz) |=> $stable(live_time));

    assert_commit_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |=> (live_time == $past(commit_time)));

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1hz    (tick_1hz),
    .rd_start    (rd_start),
    .wr_abort    (wr_abort),
    .running     (running),
    .do_commit   (do_commit),
    .commit_time (commit_time),
    .live_time   (live_time),
    .snap_time   (snap_time)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    import rtc_cal_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n, tick_1hz, rd_start, wr_start, wr_en, wr_commit, wr_abort;
    logic [2:0] addr;
    logic [7:0] wr_data, rd_data;
    int         checks = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rd_start(rd_start),
        .wr_start(wr_start), .wr_en(wr_en), .wr_commit(wr_commit),
        .wr_abort(wr_abort), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // vectors: {start, expected after one tick}, fields sec..dow
    localparam int NV = 13;
    localparam logic [111:0] VEC [NV] = '{
        {56'h58008015032402, 56'h59008015032402},
        {56'h59598015032402, 56'h00008115032402},
        {56'h5959A315032402, 56'h00008016032403},
        {56'h59591115032402, 56'h00005215032402},
        {56'h59595215032402, 56'h00004115032402},
        {56'h59595130042406, 56'h00001201052400},
        {56'h5959A328022301, 56'h00008001032302},
        {56'h5959A328022401, 56'h00008029022402},
        {56'h5959A329022401, 56'h00008001032402},
        {56'h5959A331129905, 56'h00008001010006},
        {56'h5959A330062403, 56'h00008001072404},
        {56'h5959A330012403, 56'h00008031012404},
        {56'h59591215032402, 56'h00000115032402}
    };
    localparam string VTAG [NV] = '{"R3", "R3", "R4", "R5", "R5", "R6", "R6",
                                    "R7", "R7", "R7", "R6", "R6", "R5"};

    task automatic chk_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input rtc_time_t act, input rtc_time_t exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %014h expected %014h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic read_time(output rtc_time_t t);
        rtc_bytes_t b;
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            addr = 3'(i);
            #1 b[i] = rd_data;
        end
        t = from_bytes(b);
    endtask

    task automatic open_wr();
        @(negedge clk); wr_start = 1'b1;
        @(negedge clk); wr_start = 1'b0;
    endtask

    task automatic put_byte(input int a, input logic [7:0] d);
        wr_en = 1'b1; addr = 3'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic commit_wr();
        wr_commit = 1'b1;
        @(negedge clk); wr_commit = 1'b0;
    endtask

    task automatic set_time(input rtc_time_t t);
        rtc_bytes_t b;
        b = to_bytes(t);
        open_wr();
        for (int i = 0; i < NUM_FIELDS; i++) put_byte(i, b[i]);
        commit_wr();
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rtc_time_t t, exp;
        rst_n = 1'b0; tick_1hz = 0; rd_start = 0; wr_start = 0; wr_en = 0;
        wr_commit = 0; wr_abort = 0; addr = 0; wr_data = 0;
        do_reset();

        // R1: snapshot zero before first read, then reset time
        @(negedge clk); addr = 3'd2; #1 chk_byte("R1 snapshot", rd_data, 8'h00);
        read_time(t); chk_time("R1 reset time", t, RESET_TIME);

        // R2: halted; empty commit does not start it
        tick(); tick(); tick();
        read_time(t); chk_time("R2 halted", t, RESET_TIME);
        open_wr(); commit_wr(); tick();
        read_time(t); chk_time("R2 empty commit", t, RESET_TIME);
        // single byte write starts the clock (R11 single byte)
        open_wr(); put_byte(FLD_SEC, 8'h10); commit_wr(); tick();
        exp = RESET_TIME; exp.sec = 8'h11;
        read_time(t); chk_time("R2 R11 start by one byte", t, exp);

        // R9: snapshot frozen across ticks
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        tick(); tick();
        addr = 3'd0; #1 chk_byte("R9 frozen snapshot", rd_data, 8'h11);
        addr = 3'd7; #1 chk_byte("R9 addr7 zero", rd_data, 8'h00);
        read_time(t); exp.sec = 8'h13; chk_time("R9 live advanced", t, exp);

        // R10: staged write leaves live alone; addr 7 ignored
        open_wr();
        put_byte(FLD_MIN, 8'h30);
        put_byte(7, 8'hFF);
        tick();
        read_time(t); exp.sec = 8'h14; chk_time("R10 live untouched", t, exp);
        commit_wr();
        read_time(t); exp.sec = 8'h13; exp.min = 8'h30;
        chk_time("R11 commit from shadow", t, exp);
        @(negedge clk); addr = 3'd7; #1 chk_byte("R10 addr7 write ignored", rd_data, 8'h00);

        // R10: wr_en outside a transaction
        @(negedge clk); put_byte(FLD_SEC, 8'h45);
        read_time(t); chk_time("R10 write outside txn", t, exp);

        // R12: abort discards, then stray commit ignored
        open_wr(); put_byte(FLD_HOUR, 8'h85);
        wr_abort = 1'b1; @(negedge clk); wr_abort = 1'b0;
        commit_wr();
        read_time(t); chk_time("R12 abort", t, exp);
        // R12: abort beats commit in the same cycle
        open_wr(); put_byte(FLD_HOUR, 8'h85);
        wr_abort = 1'b1; wr_commit = 1'b1;
        @(negedge clk); wr_abort = 1'b0; wr_commit = 1'b0;
        read_time(t); chk_time("R12 abort over commit", t, exp);

        // R13 and R11: tick and byte in the commit cycle
        open_wr(); put_byte(FLD_SEC, 8'h40);
        wr_en = 1'b1; addr = 3'(FLD_MIN); wr_data = 8'h45;
        wr_commit = 1'b1; tick_1hz = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_commit = 1'b0; tick_1hz = 1'b0;
        read_time(t); exp.sec = 8'h40; exp.min = 8'h45;
        chk_time("R13 tick dropped, R11 same-cycle byte", t, exp);
        tick();
        read_time(t); exp.sec = 8'h41; chk_time("R11 counts from commit", t, exp);

        // table of one-tick carries (R3 R4 R5 R6 R7 R8)
        for (int v = 0; v < NV; v++) begin
            set_time(rtc_time_t'(VEC[v][111:56]));
            tick();
            read_time(t);
            chk_time({VTAG[v], " R8 vector"}, t, rtc_time_t'(VEC[v][55:0]));
        end

        // R1 R2: reset again halts
        do_reset();
        tick();
        read_time(t); chk_time("R1 R2 reset mid-run", t, RESET_TIME);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule